// File: doc/BRIEF.md
# DRAM Access and Refresh Sequencer

This block drives one bank of 32-bit DRAM for a processor bus whose cycles end when the memory returns a termination strobe. It has two sequencers and an arbiter. One sequencer runs normal reads and writes. The other runs CAS-before-RAS refresh. The arbiter hands the DRAM to exactly one of them at a time and never lets their sequences overlap.

A periodic refresh tick is caught in a pending flag. The flag waits until the memory cycle in progress has finished, then claims the DRAM before any further access. A processor cycle that arrives during a refresh is held off. The processor keeps its request asserted until it sees the termination strobe. For writes, the byte-lane CAS strobes come from the transfer size and the low address bits. Reads and refreshes strobe all four lanes.

All DRAM-side outputs are active high. Inversion for the pads is left to the pad ring.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `ras_on`, `cas_on`, `dram_we`, `col_sel` and `cyc_term` are all 0.
- R2: An access raises `ras_on` with `col_sel` low for RAS_CYC cycles. It then sets `col_sel` for MUX_CYC cycles. It then asserts CAS and `cyc_term` together for exactly one cycle. From an idle block, `cyc_term` appears RAS_CYC+MUX_CYC+1 cycles after the first clock edge that samples the request.
- R3: On a write, `cas_on[i]` (lane i = byte offset i) is set for offsets from `addr_lo` up to offset 3, limited to the transfer length. Size 01 is 1 byte, 10 is 2 bytes, 11 is 3 bytes and 00 is 4 bytes. `dram_we` is 1 during the strobe cycle.
- R4: On a read (`rd_wr`=1), all four CAS lanes are set in the strobe cycle, and `dram_we` stays 0 for the whole access.
- R5: A refresh asserts all four CAS lanes for CBR_LEAD cycles with `ras_on` low, then raises `ras_on` for RFR_CYC cycles while CAS stays on.
- R6: `dram_we` is 0 throughout a refresh.
- R7: A refresh tick seen while the block is idle starts the refresh (CAS on, RAS off) two cycles after the edge that samples the tick.
- R8: A tick that arrives during an access does not disturb that access. The refresh runs after the access's precharge and before a later access that is already waiting, and it does not overlap any access.
- R9: Each tick produces exactly one refresh. The pending flag is cleared at the end of the refresh.
- R10: `ras_on` stays low for at least PRE_CYC cycles after every access or refresh.
- R11: If a refresh is pending and a memory request is present when the DRAM becomes free, the refresh is granted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_tick | input | 1 | One-cycle refresh interval pulse |
| mem_sel | input | 1 | Address decoder selects the DRAM range |
| addr_strobe | input | 1 | Processor address strobe, active high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| xfer_size | input | 2 | Transfer size code (01 byte, 10 word, 11 three bytes, 00 long) |
| addr_lo | input | 2 | Byte offset within the 32-bit word |
| ras_on | output | 1 | Row strobe, active high |
| cas_on | output | 4 | Byte-lane column strobes, active high |
| dram_we | output | 1 | DRAM write enable, active high |
| col_sel | output | 1 | Address mux: 0 = row, 1 = column |
| cyc_term | output | 1 | Synchronous cycle termination to the processor |

## Verification
The bench builds the block with RAS_CYC=2, MUX_CYC=1, PRE_CYC=2, CBR_LEAD=1 and RFR_CYC=2. A row phase longer than one cycle exercises the phase counter's reload-and-count path, not only its single-cycle shortcut. A two-cycle precharge leaves room to place a refresh tick in the middle of an access and to set up the exact tie between a pending refresh and a waiting request at the moment the DRAM frees up. The counter-based precharge check works unchanged for larger PRE_CYC values.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_ROW,
    ACC_COL,
    ACC_STROBE,
    ACC_PRE
  } acc_state_e;

  typedef enum logic [1:0] {
    RF_IDLE,
    RF_CAS,
    RF_RAS,
    RF_PRE
  } rfr_state_e;

  localparam int LANES = 4;

  // Number of bytes moved by a size code (00 means a full 32-bit word).
  function automatic int size_bytes(input logic [1:0] size);
    return (size == 2'b00) ? LANES : int'(size);
  endfunction

  // Byte lanes touched by a write: from the offset upward, clipped at the port end.
  function automatic logic [LANES-1:0] write_lanes(input logic [1:0] size,
                                                   input logic [1:0] off);
    logic [LANES-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i >= int'(off) && i < int'(off) + size_bytes(size)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dram_arbiter.sv
module dram_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic refresh_tick,
  input  logic rfr_done,
  input  logic acc_ready,
  input  logic rfr_ready,
  input  logic mem_req,
  output logic rfr_pend,
  output logic grant_acc,
  output logic grant_rfr
);

  logic dram_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rfr_pend <= 1'b0;
    else if (refresh_tick) rfr_pend <= 1'b1;
    else if (rfr_done)     rfr_pend <= 1'b0;
  end

  assign dram_free = acc_ready && rfr_ready;
  assign grant_rfr = dram_free && rfr_pend;
  assign grant_acc = dram_free && !rfr_pend && mem_req;

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq #(
  parameter int RAS_CYC = 1,
  parameter int MUX_CYC = 1,
  parameter int PRE_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd_wr,
  input  logic [1:0] xfer_size,
  input  logic [1:0] addr_lo,
  output logic       ready,
  output logic       active,
  output logic       ras,
  output logic       col,
  output logic [3:0] cas,
  output logic       we,
  output logic       term
);
  import dram_ctrl_pkg::*;

  localparam int CNT_W = $clog2(max3(RAS_CYC, MUX_CYC, PRE_CYC) + 1);

  acc_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             rd_q;
  logic [1:0]       size_q;
  logic [1:0]       off_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign ready    = (state == ACC_IDLE) || (state == ACC_PRE && cnt_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ACC_IDLE;
      cnt    <= '0;
      rd_q   <= 1'b1;
      size_q <= 2'b00;
      off_q  <= 2'b00;
    end else if (ready && start) begin
      state  <= ACC_ROW;
      cnt    <= CNT_W'(RAS_CYC - 1);
      rd_q   <= rd_wr;
      size_q <= xfer_size;
      off_q  <= addr_lo;
    end else begin
      case (state)
        ACC_ROW: begin
          if (cnt_zero) begin
            state <= ACC_COL;
            cnt   <= CNT_W'(MUX_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ACC_COL: begin
          if (cnt_zero) state <= ACC_STROBE;
          else cnt <= cnt - 1'b1;
        end
        ACC_STROBE: begin
          state <= ACC_PRE;
          cnt   <= CNT_W'(PRE_CYC - 1);
        end
        ACC_PRE: begin
          if (cnt_zero) state <= ACC_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= ACC_IDLE;
      endcase
    end
  end

  assign active = (state == ACC_ROW) || (state == ACC_COL) || (state == ACC_STROBE);
  assign ras    = active;
  assign col    = (state == ACC_COL) || (state == ACC_STROBE);
  assign term   = (state == ACC_STROBE);
  assign we     = active && !rd_q;
  assign cas    = term ? (rd_q ? 4'hF : write_lanes(size_q, off_q)) : 4'h0;

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int CBR_LEAD = 1,
  parameter int RFR_CYC  = 2,
  parameter int PRE_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       ready,
  output logic       active,
  output logic       ras,
  output logic [3:0] cas,
  output logic       done
);
  import dram_ctrl_pkg::*;

  localparam int CNT_W = $clog2(max3(CBR_LEAD, RFR_CYC, PRE_CYC) + 1);

  rfr_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign ready    = (state == RF_IDLE) || (state == RF_PRE && cnt_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RF_IDLE;
      cnt   <= '0;
    end else if (ready && start) begin
      state <= RF_CAS;
      cnt   <= CNT_W'(CBR_LEAD - 1);
    end else begin
      case (state)
        RF_CAS: begin
          if (cnt_zero) begin
            state <= RF_RAS;
            cnt   <= CNT_W'(RFR_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        RF_RAS: begin
          if (cnt_zero) begin
            state <= RF_PRE;
            cnt   <= CNT_W'(PRE_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        RF_PRE: begin
          if (cnt_zero) state <= RF_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= RF_IDLE;
      endcase
    end
  end

  assign active = (state == RF_CAS) || (state == RF_RAS);
  assign ras    = (state == RF_RAS);
  assign cas    = active ? 4'hF : 4'h0;
  assign done   = (state == RF_RAS) && cnt_zero;

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int RAS_CYC  = 1,
  parameter int MUX_CYC  = 1,
  parameter int PRE_CYC  = 2,
  parameter int CBR_LEAD = 1,
  parameter int RFR_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refresh_tick,
  input  logic       mem_sel,
  input  logic       addr_strobe,
  input  logic       rd_wr,
  input  logic [1:0] xfer_size,
  input  logic [1:0] addr_lo,
  output logic       ras_on,
  output logic [3:0] cas_on,
  output logic       dram_we,
  output logic       col_sel,
  output logic       cyc_term
);

  logic       mem_req;
  logic       rfr_pend, grant_acc, grant_rfr, rfr_done;
  logic       acc_ready, acc_active, acc_ras, acc_col, acc_we, acc_term;
  logic       rfr_ready, rfr_active, rfr_ras;
  logic [3:0] acc_cas, rfr_cas;

  assign mem_req = mem_sel && addr_strobe;

  dram_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .refresh_tick(refresh_tick), .rfr_done(rfr_done),
    .acc_ready(acc_ready), .rfr_ready(rfr_ready), .mem_req(mem_req),
    .rfr_pend(rfr_pend), .grant_acc(grant_acc), .grant_rfr(grant_rfr)
  );

  dram_access_seq #(.RAS_CYC(RAS_CYC), .MUX_CYC(MUX_CYC), .PRE_CYC(PRE_CYC)) u_acc (
    .clk(clk), .rst_n(rst_n), .start(grant_acc), .rd_wr(rd_wr),
    .xfer_size(xfer_size), .addr_lo(addr_lo), .ready(acc_ready),
    .active(acc_active), .ras(acc_ras), .col(acc_col), .cas(acc_cas),
    .we(acc_we), .term(acc_term)
  );

  dram_refresh_seq #(.CBR_LEAD(CBR_LEAD), .RFR_CYC(RFR_CYC), .PRE_CYC(PRE_CYC)) u_rfr (
    .clk(clk), .rst_n(rst_n), .start(grant_rfr), .ready(rfr_ready),
    .active(rfr_active), .ras(rfr_ras), .cas(rfr_cas), .done(rfr_done)
  );

  assign ras_on   = acc_ras | rfr_ras;
  assign cas_on   = acc_cas | rfr_cas;
  assign dram_we  = acc_we;
  assign col_sel  = acc_col;
  assign cyc_term = acc_term;

endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int PRE_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       refresh_tick,
  input logic       rd_wr,
  input logic       ras_on,
  input logic [3:0] cas_on,
  input logic       dram_we,
  input logic       col_sel,
  input logic       cyc_term,
  input logic       acc_active,
  input logic       rfr_active,
  input logic       rfr_pend,
  input logic       grant_acc,
  input logic       rfr_done
);

  localparam int LW = $clog2(PRE_CYC + 2);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     low_cnt <= LW'(PRE_CYC);
    else if (ras_on)                low_cnt <= '0;
    else if (low_cnt < LW'(PRE_CYC)) low_cnt <= low_cnt + 1'b1;
  end

  a_r2_col_after_row: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_sel) |-> ras_on && $past(ras_on));

  a_r2_term_in_column: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_term |-> ras_on && col_sel && $past(col_sel) && (cas_on != 4'h0));

  a_r2_term_single: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_term |=> !cyc_term);

  a_r4_read_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_term && rd_wr |-> (cas_on == 4'hF) && !dram_we);

  a_r5_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    rfr_active && $rose(ras_on) |-> $past(cas_on) == 4'hF);

  a_r6_no_write_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    rfr_active |-> !dram_we);

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rfr_active && acc_active));

  a_r9_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rfr_done && !refresh_tick |=> !rfr_pend);

  a_r10_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_on) |-> low_cnt >= LW'(PRE_CYC));

  a_r11_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
    grant_acc |-> !rfr_pend);

endmodule

bind dram_refresh_ctrl dram_refresh_chk #(.PRE_CYC(PRE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .refresh_tick(refresh_tick), .rd_wr(rd_wr),
  .ras_on(ras_on), .cas_on(cas_on), .dram_we(dram_we), .col_sel(col_sel),
  .cyc_term(cyc_term), .acc_active(acc_active), .rfr_active(rfr_active),
  .rfr_pend(rfr_pend), .grant_acc(grant_acc), .rfr_done(rfr_done)
);

// File: tb/test_dram_refresh_ctrl.sv
module test_dram_refresh_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int RAS_CYC  = 2;
  localparam int MUX_CYC  = 1;
  localparam int PRE_CYC  = 2;
  localparam int CBR_LEAD = 1;
  localparam int RFR_CYC  = 2;
  localparam int ACC_LAT  = RAS_CYC + MUX_CYC + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       refresh_tick = 1'b0;
  logic       mem_sel = 1'b0;
  logic       addr_strobe = 1'b0;
  logic       rd_wr = 1'b1;
  logic [1:0] xfer_size = 2'b00;
  logic [1:0] addr_lo = 2'b00;
  logic       ras_on, dram_we, col_sel, cyc_term;
  logic [3:0] cas_on;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  dram_refresh_ctrl #(.RAS_CYC(RAS_CYC), .MUX_CYC(MUX_CYC), .PRE_CYC(PRE_CYC),
                      .CBR_LEAD(CBR_LEAD), .RFR_CYC(RFR_CYC)) i_dram_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .refresh_tick(refresh_tick), .mem_sel(mem_sel),
    .addr_strobe(addr_strobe), .rd_wr(rd_wr), .xfer_size(xfer_size),
    .addr_lo(addr_lo), .ras_on(ras_on), .cas_on(cas_on), .dram_we(dram_we),
    .col_sel(col_sel), .cyc_term(cyc_term)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", cycles, 20000);
      finish_run();
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  // Lanes computed by shifting a run of ones up to the offset.
  function automatic logic [3:0] exp_lanes(input logic [1:0] size, input logic [1:0] off);
    logic [7:0] run;
    case (size)
      2'b01:   run = 8'h01;
      2'b10:   run = 8'h03;
      2'b11:   run = 8'h07;
      default: run = 8'h0F;
    endcase
    run = run << off;
    return run[3:0];
  endfunction

  task automatic drive_req(input bit rd, input logic [1:0] size, input logic [1:0] off);
    mem_sel = 1'b1; addr_strobe = 1'b1; rd_wr = rd; xfer_size = size; addr_lo = off;
  endtask

  task automatic drop_req();
    mem_sel = 1'b0; addr_strobe = 1'b0;
  endtask

  // One access from idle; checks ordering, latency, lanes, WE and precharge.
  task automatic do_access(input bit rd, input logic [1:0] size, input logic [1:0] off);
    int  lat = 0;
    bit  order_ok = 1'b1, saw_ras = 1'b0, saw_col_only = 1'b0, we_ok = 1'b1, pre_ok = 1'b1;
    logic [3:0] exp;
    exp = rd ? 4'hF : exp_lanes(size, off);
    drive_req(rd, size, off);
    while (!cyc_term && lat < 40) begin
      step(); lat++;
      if (col_sel && !saw_ras) order_ok = 1'b0;
      if (ras_on && !col_sel) saw_ras = 1'b1;
      if (col_sel && cas_on == 4'h0) saw_col_only = 1'b1;
      if (!cyc_term && cas_on != 4'h0) order_ok = 1'b0;
      if (rd && dram_we) we_ok = 1'b0;
    end
    chk(lat == ACC_LAT, "R2 latency", lat, ACC_LAT);
    chk(order_ok && saw_ras && saw_col_only, "R2 ras/mux/cas order", order_ok, 1);
    if (rd) begin
      chk(cas_on == 4'hF, "R4 read lanes", cas_on, 4'hF);
      chk(we_ok, "R4 no write enable", we_ok, 1);
    end else begin
      chk(cas_on == exp, "R3 write lanes", cas_on, exp);
      chk(dram_we, "R3 write enable", dram_we, 1);
    end
    drop_req();
    for (int i = 0; i < PRE_CYC; i++) begin
      step();
      if (ras_on || cas_on != 4'h0) pre_ok = 1'b0;
    end
    chk(pre_ok, "R10 precharge after access", pre_ok, 1);
  endtask

  // Tick from idle: CBR signature, latency, WE off, single refresh.
  task automatic idle_refresh();
    int  first = 0, rises = 0;
    bit  prev_ras = 1'b0, we_ok = 1'b1, cbr_ok = 1'b1;
    refresh_tick = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      step();
      if (i == 1) refresh_tick = 1'b0;
      if (first == 0 && cas_on != 4'h0) begin
        first = i;
        if (ras_on || cas_on != 4'hF) cbr_ok = 1'b0;
      end
      if (ras_on && !prev_ras && cas_on != 4'hF) cbr_ok = 1'b0;
      if (ras_on && !prev_ras) rises++;
      if (dram_we) we_ok = 1'b0;
      prev_ras = ras_on;
    end
    chk(first == 2, "R7 refresh start latency", first, 2);
    chk(cbr_ok, "R5 cas before ras", cbr_ok, 1);
    chk(we_ok, "R6 write enable off in refresh", we_ok, 1);
    chk(rises == 1, "R9 one refresh per tick", rises, 1);
  endtask

  // Tick during an access; a second access waits behind the refresh.
  task automatic preempt_refresh();
    int  lat = 0, wait_n = 0;
    bit  clean = 1'b1, rfr_first = 1'b0, seen = 1'b0;
    drive_req(1'b0, 2'b10, 2'b10);
    step(); lat++;
    refresh_tick = 1'b1;
    step(); lat++;
    refresh_tick = 1'b0;
    while (!cyc_term && lat < 40) begin
      if (cas_on != 4'h0) clean = 1'b0;
      step(); lat++;
    end
    chk(lat == ACC_LAT && cas_on == 4'b1100, "R8 access undisturbed", {lat[7:0], cas_on}, {8'(ACC_LAT), 4'b1100});
    drop_req();
    step();
    drive_req(1'b1, 2'b00, 2'b00);
    while (!cyc_term && wait_n < 40) begin
      step(); wait_n++;
      if (!seen && cas_on != 4'h0) begin
        seen = 1'b1;
        rfr_first = !ras_on && !cyc_term && !col_sel;
      end
    end
    chk(clean, "R8 no refresh inside access", clean, 1);
    chk(rfr_first, "R8 refresh before waiting access", rfr_first, 1);
    chk(cyc_term && cas_on == 4'hF, "R8 waiting access completes", cyc_term, 1);
    drop_req();
    repeat (PRE_CYC + 2) step();
  endtask

  // Pending refresh and request present together when the DRAM is free.
  task automatic tie_refresh();
    int  n = 0;
    bit  got = 1'b0;
    refresh_tick = 1'b1;
    step();
    refresh_tick = 1'b0;
    drive_req(1'b1, 2'b00, 2'b00);
    step();
    got = (cas_on == 4'hF) && !ras_on && !col_sel;
    chk(got, "R11 refresh wins tie", {cas_on, ras_on}, 5'b11110);
    while (!cyc_term && n < 40) begin step(); n++; end
    chk(cyc_term, "R11 request served after refresh", cyc_term, 1);
    drop_req();
    repeat (PRE_CYC + 2) step();
  endtask

  initial begin
    repeat (3) step();
    chk(!ras_on && cas_on == 4'h0 && !dram_we && !col_sel && !cyc_term,
        "R1 outputs in reset", {ras_on, cas_on, dram_we, col_sel, cyc_term}, 0);
    rst_n = 1'b1;
    step();
    chk(!ras_on && cas_on == 4'h0 && !dram_we && !col_sel && !cyc_term,
        "R1 outputs after reset", {ras_on, cas_on, dram_we, col_sel, cyc_term}, 0);
    do_access(1'b1, 2'b01, 2'b10);
    do_access(1'b0, 2'b01, 2'b00);
    do_access(1'b0, 2'b01, 2'b11);
    do_access(1'b0, 2'b10, 2'b00);
    do_access(1'b0, 2'b10, 2'b11);
    do_access(1'b0, 2'b11, 2'b01);
    do_access(1'b0, 2'b00, 2'b00);
    do_access(1'b0, 2'b00, 2'b10);
    idle_refresh();
    preempt_refresh();
    tie_refresh();
    idle_refresh();
    done = 1'b1;
    finish_run();
  end

endmodule